// File: doc/BRIEF.md
# Comparator-Loop Sigma-Delta Voltage Converter

This block turns a slowly varying analog voltage between 0 V and 3.3 V into an unsigned 8-bit code. The only analog parts are one external fast comparator and an RC network. The comparator compares the input voltage against the RC node. The block samples the comparator decision on one input pin and drives the RC network from one output pin. This closes a first-order feedback loop through the fabric, so the RC node follows the input. The density of ones on the feedback pin is then proportional to the input voltage.

A box-car averager reduces that bitstream to a code. A window counter divides time into windows of 255 samples. Within each window, the accumulator counts the ones seen. When the window rolls over, the count is latched as the result, the accumulator restarts from zero, and a one-cycle valid strobe marks the new code. A steady full-scale input reads 8'hFF and a grounded input reads 8'h00.

Top module: `cmp_sd_adc`

## Requirements
- R1: The comparator pin passes through two flip-flops before use. The feedback output `fbOut` always equals the level that `cmpIn` had two rising edges earlier, and it is updated on every clock.
- R2: An averaging window spans exactly 255 clock cycles. Consecutive `resultValid` pulses are exactly 255 cycles apart.
- R3: `resultValid` is high for exactly one cycle per window.
- R4: The latched code equals the number of ones in the synchronized bitstream over the 255 samples of the window. The accumulator restarts from zero at rollover, so no count carries into the next window.
- R5: With the comparator held high for a whole window the code is 8'hFF, and held low it is 8'h00. With the loop closed, an input of 3.3 V reads 8'hFF and an input of 0 V reads 8'h00.
- R6: With the loop closed through a first-order RC node, the settled code lies within ±2 LSB of round(Vin × 255 / 3.3).
- R7: `result` changes only in the cycle in which `resultValid` is high, and it holds its value between pulses.
- R8: An active-low synchronous reset clears the result, the valid strobe, the accumulator, the window counter and the synchronizer, so `fbOut` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and loop clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmpIn | input | 1 | Comparator decision: 1 when the input is above the RC node |
| fbOut | output | 1 | Feedback drive to the RC network |
| result | output | 8 | Latched conversion code |
| resultValid | output | 1 | One-cycle strobe marking a new code |

## Verification
Every cycle, the assertions check four things. First, the feedback pin lags the comparator pin by exactly two edges. Second, the valid strobe never lasts two cycles and the code moves only with it. Third, the accumulator stays within the window length, and the window counter restarts after each rollover. Fourth, reset clears the outputs. Only the bench scenarios can show the 255-cycle window period and the exact counts for forced comparator levels. They also show that a level change does not leak into the next window, and that the closed loop settles within ±2 LSB of the expected code for a range of input voltages.

// File: rtl/adc_pkg.sv
package adc_pkg;

  // Strobes handed from the window control to the datapath.
  typedef struct packed {
    logic accumulate;  // add the current synchronized bit
    logic rollover;    // last sample of the window: latch and restart
  } adcCtrl_t;

endpackage

// File: rtl/adc_ctrl.sv
module adc_ctrl
  import adc_pkg::*;
#(
  parameter int WINDOW      = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  output adcCtrl_t ctrl
);

  localparam int CNT_W  = $clog2(WINDOW);
  localparam int FILL_W = $clog2(SYNC_STAGES + 1);

  logic [CNT_W-1:0]  winCnt;
  logic [FILL_W-1:0] fillCnt;
  logic              running;
  logic              lastSample;

  // Hold off until the synchronizer has filled with real samples.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      running <= 1'b0;
    end else if (!running) begin
      if (fillCnt == FILL_W'(SYNC_STAGES - 1)) running <= 1'b1;
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign lastSample = running && (winCnt == CNT_W'(WINDOW - 1));

  always_ff @(posedge clk) begin
    if (!rstN)          winCnt <= '0;
    else if (lastSample) winCnt <= '0;
    else if (running)    winCnt <= winCnt + 1'b1;
  end

  always_comb begin
    ctrl.accumulate = running;
    ctrl.rollover   = lastSample;
  end

  // R2
  window_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rollover |=> (winCnt == '0));

  // R2
  window_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= CNT_W'(WINDOW - 1));

endmodule

// File: rtl/adc_datapath.sv
module adc_datapath
  import adc_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int WINDOW      = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  adcCtrl_t         ctrl,
  input  logic             cmpIn,
  output logic             fbOut,
  output logic [RES_W-1:0] result,
  output logic             resultValid
);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   sampleBit;
  logic [RES_W-1:0]       acc;
  logic [RES_W-1:0]       accPlusBit;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[0] <= 1'b0;
          else       syncReg[0] <= cmpIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncReg[s] <= 1'b0;
          else       syncReg[s] <= syncReg[s-1];
        end
      end
    end
  endgenerate

  assign sampleBit  = syncReg[SYNC_STAGES-1];
  assign fbOut      = sampleBit;
  assign accPlusBit = acc + {{(RES_W-1){1'b0}}, sampleBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (ctrl.rollover) begin
        result      <= accPlusBit;
        acc         <= '0;
        resultValid <= 1'b1;
      end else if (ctrl.accumulate) begin
        acc <= accPlusBit;
      end
    end
  end

  // Cycles since reset, saturating, so $past never reaches into reset.
  logic [1:0] ageCnt;
  always_ff @(posedge clk) begin
    if (!rstN)           ageCnt <= '0;
    else if (ageCnt != 2'd3) ageCnt <= ageCnt + 1'b1;
  end

  // R1
  fb_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt >= 2'd2) |-> (fbOut == $past(cmpIn, 2)));

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt != 2'd0 && !$stable(result)) |-> resultValid);

  // R4
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc <= RES_W'(WINDOW - 1));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (result == '0 && !resultValid && !fbOut));

endmodule

// File: rtl/cmp_sd_adc.sv
module cmp_sd_adc
  import adc_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmpIn,
  output logic             fbOut,
  output logic [RES_W-1:0] result,
  output logic             resultValid
);

  localparam int WINDOW = (1 << RES_W) - 1;

  adcCtrl_t ctrl;

  adc_ctrl #(.WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl)
  );

  adc_datapath #(.RES_W(RES_W), .WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .cmpIn       (cmpIn),
    .fbOut       (fbOut),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: tb/cmp_sd_adc_test.sv
module cmp_sd_adc_test;

  localparam int  CLK_PERIOD = 10;
  localparam int  NVEC = 8;
  localparam int  VIN_MV [NVEC] = '{0, 3300, 1650, 500, 2800, 1000, 2200, 3000};
  localparam real ALPHA = 0.005;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpIn;
  logic       fbOut;
  logic [7:0] result;
  logic       resultValid;

  logic useModel = 1'b0;
  logic forced   = 1'b0;
  real  vin      = 0.0;
  real  vnode    = 0.0;
  int   checks   = 0;
  int   fails    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_sd_adc uut (
    .clk(clk), .rstN(rstN), .cmpIn(cmpIn),
    .fbOut(fbOut), .result(result), .resultValid(resultValid)
  );

  // First-order RC node model and comparator, updated away from the active edge.
  always @(negedge clk) begin
    vnode = vnode + ALPHA * ((fbOut ? 3.3 : 0.0) - vnode);
  end
  assign cmpIn = useModel ? (vin > vnode) : forced;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitValid(output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!resultValid && waited < 2000);
  endtask

  initial begin
    int w;
    int exp;
    int diff;
    logic h0, h1;
    logic [7:0] held;

    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", result == 8'h00 && !resultValid && !fbOut, result, 0);
    rstN = 1'b1;

    // R1: feedback lags comparator by two edges
    forced = 1'b1; @(negedge clk); h0 = 1'b1;
    forced = 1'b0; @(negedge clk); h1 = 1'b0;
    check("R1", fbOut == h0, fbOut, h0);
    forced = 1'b1; @(negedge clk);
    check("R1", fbOut == h1, fbOut, h1);
    forced = 1'b1; @(negedge clk);
    check("R1", fbOut == 1'b1, fbOut, 1);

    // R5/R4: forced high gives 255; R2 period; R3 single pulse
    waitValid(w); waitValid(w);
    check("R5", result == 8'hFF, result, 255);
    @(negedge clk);
    check("R3", !resultValid, resultValid, 0);
    held = result;
    repeat (100) @(negedge clk);
    check("R7", result == held && !resultValid, result, held);
    waitValid(w);
    check("R2", w == 154, w + 101, 255);
    waitValid(w);
    check("R2", w == 255, w, 255);

    // R4: the window after a level change carries nothing from before
    forced = 1'b0;
    waitValid(w); waitValid(w);
    check("R4", result == 8'h00, result, 0);

    // R4: comparator high for a quarter of cycles -> 63 or 64 ones
    fork
      begin
        for (int k = 0; k < 1200; k++) begin
          forced = (k % 4 == 0);
          @(negedge clk);
        end
      end
      begin
        waitValid(w); waitValid(w);
        check("R4", result == 8'd63 || result == 8'd64, result, 64);
      end
    join

    // R6/R5: closed loop, table walk
    useModel = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      vin = VIN_MV[i] / 1000.0;
      exp = (VIN_MV[i] * 255 + 1650) / 3300;
      repeat (4) waitValid(w);
      diff = int'(result) - exp;
      if (VIN_MV[i] == 0 || VIN_MV[i] == 3300)
        check("R5", result == 8'(exp), result, exp);
      else
        check("R6", diff >= -2 && diff <= 2, result, exp);
    end

    // R8: reset mid-window clears everything
    repeat (77) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", result == 8'h00 && !resultValid && !fbOut, result, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule